// File: doc/BRIEF.md
# I2C register-map control port

This block is a slave on a two-wire I2C bus that gives a host access to a small bank of byte-wide configuration registers. Both bus lines are oversampled with the system clock and synchronised, and START and STOP conditions are detected. The slave answers one 7-bit device address. Its upper six bits are fixed and its lowest bit comes from a strap pin, so two of these ports can share one bus.

A write transfer carries a map byte right after the address. The map byte selects a register and can turn on auto-increment. The data bytes that follow are stored starting at that register. A read transfer has no way to carry a map byte. It returns data from wherever the map pointer was left, so a host normally sends a short write with only the map byte and a STOP, then starts the read.

Register 0 is a control register. Its bit 0 is a run bit that holds the downstream digital logic in reset until software sets it. The highest implemented index is a read-only status register whose value comes from an input port.

Top module: `i2c_map_port`

## Requirements
- R1: The slave acknowledges an address byte whose bits 7:1 equal 0b001000 followed by `addr_strap_i`. Bit 0 of the address byte is the direction: 0 means write, 1 means read. On any other address the slave leaves SDA released and ignores traffic until the next START.
- R2: In a write transfer the first byte after the address is the map byte, and the slave acknowledges it. Bit 7 is the auto-increment enable and bits 6:0 are the register index.
- R3: Each later byte of a write transfer is acknowledged and stored in the register the map pointer selects. That register's value appears at `regs_o[8*i +: 8]`.
- R4: With auto-increment set, the pointer advances by one after every data byte, on writes and on reads alike. It wraps from index 0x7F to 0x00.
- R5: With auto-increment clear, the pointer stays fixed. Repeated writes overwrite the same register, and repeated reads return the same register.
- R6: A read transfer returns bytes MSB first, starting at the current map pointer. The master acknowledges (SDA low) to get another byte. A not-acknowledge releases the bus and ends the read.
- R7: Index STATUS_IDX (7 by default) reads the value of `status_i`. Writes to it are acknowledged and have no effect.
- R8: Indices at or above NUM_REGS read as 0x00, and data written to them is discarded.
- R9: The control register at index 0 resets to 0x00. `core_rst_o` is 1 exactly while bit 0 of that register is 0.
- R10: While `rst_ni` is low, every register holds its reset value of 0x00 and the port does not answer the bus.
- R11: `sda_oe_o` changes only while SCL is low. A repeated START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| scl_o | output | 1 | SCL output value, always 0 |
| scl_oe_o | output | 1 | SCL pull-down enable, always 0 (no clock stretching) |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_o | output | 1 | SDA output value, always 0 (open drain) |
| sda_oe_o | output | 1 | SDA pull-down enable, 1 pulls SDA low |
| addr_strap_i | input | 1 | Strap that sets the lowest device-address bit |
| status_i | input | 8 | Value returned by the read-only status register |
| regs_o | output | 8*NUM_REGS | Register contents, index i in bits 8*i+7:8*i |
| core_rst_o | output | 1 | Reset for downstream digital logic, 1 while the run bit is 0 |

## Verification
The bench builds the block with NUM_REGS = 8 and STATUS_IDX = 7, and ties the strap high. With those values both the status slot and indices above the implemented range can be addressed. A map byte of 0xFF then shows the 0x7F-to-0x00 wrap, as one discarded byte followed by a write landing in the control register. Mismatched addresses, repeated STARTs and bus traffic during reset are driven by a bit-level bus master whose SDA is wired-AND with the slave's pull-down.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;
  localparam int unsigned IDX_W = 7;
  localparam logic [5:0] DEV_ADDR_HI = 6'b001000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MAP,
    ST_MAP_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } xfer_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // idle bus is high, so flops reset high to avoid false conditions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[LAST];
      sda_q  <= sda_ff[LAST];
    end
  end

  assign scl_o      = scl_ff[LAST];
  assign sda_o      = sda_ff[LAST];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o
);
  xfer_state_e      state_q;
  logic [2:0]       cnt_q;
  logic [7:0]       sh_q, tx_q;
  logic [IDX_W-1:0] ptr_q;
  logic             inc_q, rnw_q, ack_on_q, mack_q;
  logic [7:0]       byte_in;
  logic             last_bit;

  assign byte_in  = {sh_q[6:0], sda_s_i};
  assign last_bit = (cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      inc_q    <= 1'b0;
      rnw_q    <= 1'b0;
      ack_on_q <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
      mack_q   <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      ack_on_q <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_MAP, ST_WDATA: begin
          if (scl_rise_i) begin
            sh_q  <= byte_in;
            cnt_q <= cnt_q + 3'd1;
            if (last_bit) begin
              if (state_q == ST_ADDR) begin
                if (byte_in[7:1] == {DEV_ADDR_HI, strap_i}) begin
                  rnw_q   <= byte_in[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_MAP) begin
                ptr_q   <= byte_in[IDX_W-1:0];
                inc_q   <= byte_in[7];
                state_q <= ST_MAP_ACK;
              end else begin
                if (inc_q) ptr_q <= ptr_q + 7'd1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_MAP_ACK, ST_WDATA_ACK: begin
          if (scl_fall_i) begin
            if (!ack_on_q) begin
              ack_on_q <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              cnt_q    <= '0;
              if (state_q == ST_ADDR_ACK && rnw_q) begin
                tx_q    <= rd_data_i;
                state_q <= ST_RDATA;
              end else if (state_q == ST_ADDR_ACK) begin
                state_q <= ST_MAP;
              end else begin
                state_q <= ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            tx_q  <= {tx_q[6:0], 1'b0};
            cnt_q <= cnt_q + 3'd1;
            if (last_bit) begin
              if (inc_q) ptr_q <= ptr_q + 7'd1;
              state_q <= ST_RDATA_ACK;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise_i) begin
            if (!sda_s_i) begin
              mack_q <= 1'b1;
              tx_q   <= rd_data_i;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (scl_fall_i && mack_q) begin
            mack_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = ack_on_q | ((state_q == ST_RDATA) & ~tx_q[7]);
  assign wr_en_o   = (state_q == ST_WDATA) & scl_rise_i & last_bit & ~start_i & ~stop_i;
  assign wr_idx_o  = ptr_q;
  assign wr_data_o = byte_in;
  assign rd_idx_o  = ptr_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_port_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 8,
  parameter int unsigned STATUS_IDX = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  input  logic [7:0]            status_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  core_rst_o
);
  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned RUN_BIT  = 0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == STATUS_IDX) begin : g_status
      assign regs_o[g*8 +: 8] = status_i;
    end else begin : g_rw
      logic [7:0] val_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                    val_q <= '0;
        else if (wr_en_i && wr_idx_i == IDX_W'(g))      val_q <= wr_data_i;
      end
      assign regs_o[g*8 +: 8] = val_q;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_o[i*8 +: 8];
    end
  end

  assign core_rst_o = ~regs_o[CTRL_IDX*8 + RUN_BIT];
endmodule

// File: rtl/i2c_map_port.sv
module i2c_map_port
  import i2c_port_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned STATUS_IDX  = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  output logic                  scl_o,
  output logic                  scl_oe_o,
  input  logic                  sda_i,
  output logic                  sda_o,
  output logic                  sda_oe_o,
  input  logic                  addr_strap_i,
  input  logic [7:0]            status_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  core_rst_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_xfer_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strap_i    (addr_strap_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .STATUS_IDX(STATUS_IDX)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .rd_idx_i   (rd_idx),
    .status_i   (status_i),
    .rd_data_o  (rd_data),
    .regs_o     (regs_o),
    .core_rst_o (core_rst_o)
  );

  assign scl_o    = 1'b0;
  assign scl_oe_o = 1'b0;
  assign sda_o    = 1'b0;
endmodule

// File: rtl/i2c_map_port_chk.sv
module i2c_map_port_chk
  import i2c_port_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        sda_oe_o,
  input logic        start,
  input logic        stop,
  input xfer_state_e state,
  input logic        wr_en,
  input logic [7:0]  ctrl_byte,
  input logic        core_rst_o
);
  // R11
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  // R1
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);

  // R11
  restart_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state == ST_ADDR));

  // R6
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (state == ST_IDLE));

  // R3
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(ctrl_byte));

  // R9
  run_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(wr_en));
endmodule

bind i2c_map_port i2c_map_port_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .start      (start_evt),
  .stop       (stop_evt),
  .state      (i_ctrl.state_q),
  .wr_en      (wr_en),
  .ctrl_byte  (regs_o[7:0]),
  .core_rst_o (core_rst_o)
);

// File: tb/test_i2c_map_port.sv
module test_i2c_map_port;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam int T          = 8;
  localparam logic [7:0] ADR_W  = 8'h22;
  localparam logic [7:0] ADR_R  = 8'h23;
  localparam logic [7:0] ADR_BAD = 8'h20;
  localparam logic [7:0] STAT   = 8'hC3;
  localparam int NVEC = 7;
  // {map index, written data, expected readback}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h01, 8'hA5, 8'hA5},
    {8'h02, 8'h3C, 8'h3C},
    {8'h06, 8'hFF, 8'hFF},
    {8'h07, 8'h55, STAT},
    {8'h08, 8'h77, 8'h00},
    {8'h7F, 8'h12, 8'h00},
    {8'h05, 8'h0F, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_o, scl_oe, sda_o, sda_oe, core_rst;
  logic [NREG*8-1:0] regs;
  logic sda_bus;
  int n_chk = 0, n_err = 0, edge_viol = 0;

  assign sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_map_port #(.NUM_REGS(NREG), .STATUS_IDX(7)) i_i2c_map_port (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (m_scl),
    .scl_o        (scl_o),
    .scl_oe_o     (scl_oe),
    .sda_i        (sda_bus),
    .sda_o        (sda_o),
    .sda_oe_o     (sda_oe),
    .addr_strap_i (1'b1),
    .status_i     (STAT),
    .regs_o       (regs),
    .core_rst_o   (core_rst)
  );

  // R11: pull-down enable must not move while SCL is high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (m_scl && prev_scl && sda_oe !== prev_oe) edge_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt(T);
    m_scl = 1'b1; wt(T);
    m_sda = 1'b0; wt(T);
    m_scl = 1'b0; wt(2);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt(T);
    m_scl = 1'b1; wt(T);
    m_sda = 1'b1; wt(T);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wt(T);
    m_scl = 1'b1; wt(T);
    m_scl = 1'b0; wt(2);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wt(T);
    m_scl = 1'b1; wt(T/2);
    b = sda_bus; wt(T/2);
    m_scl = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~more);
  endtask

  task automatic set_map(input logic [7:0] map, output logic [1:0] acks);
    i2c_start();
    send_byte(ADR_W, acks[1]);
    send_byte(map, acks[0]);
    i2c_stop();
  endtask

  logic [2:0] a3;
  logic [1:0] a2;
  logic a;
  logic [7:0] d0, d1, d2;

  initial begin
    wt(5);
    // R10 R9: reset state
    chk("R10 regs after reset", 32'(regs), 32'({8'h00, STAT, 48'h0}) & 32'hFFFFFFFF);
    chk("R9 core_rst_o in reset", 32'(core_rst), 32'd1);
    rst_n = 1'b1;
    wt(5);
    chk("R10 sda released", 32'(sda_oe), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      i2c_start();
      send_byte(ADR_W, a3[2]);
      send_byte(VEC[v][23:16], a3[1]);
      send_byte(VEC[v][15:8], a3[0]);
      i2c_stop();
      chk("R2/R3/R7 write acks", 32'(a3), 32'h7);
      set_map(VEC[v][23:16], a2);
      i2c_start();
      send_byte(ADR_R, a);
      recv_byte(d0, 1'b0);
      i2c_stop();
      chk("R3/R7/R8 readback", 32'(d0), 32'(VEC[v][7:0]));
    end
    chk("R7 status slot unchanged", 32'(regs[56 +: 8]), 32'(STAT));

    // R9: set run bit
    chk("R9 core_rst_o before run", 32'(core_rst), 32'd1);
    i2c_start(); send_byte(ADR_W, a); send_byte(8'h00, a); send_byte(8'h01, a); i2c_stop();
    chk("R9 core_rst_o released", 32'(core_rst), 32'd0);

    // R4 auto-increment write then R6 auto-increment read
    i2c_start(); send_byte(ADR_W, a); send_byte(8'h83, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); i2c_stop();
    chk("R4 inc write reg3..5", 32'({regs[40 +: 8], regs[32 +: 8], regs[24 +: 8]}), 32'h332211);
    set_map(8'h83, a2);
    i2c_start(); send_byte(ADR_R, a);
    chk("R1 read address ack", 32'(a), 32'd1);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0); i2c_stop();
    chk("R6 inc read burst", 32'({d0, d1, d2}), 32'h112233);
    chk("R6 bus released after nack", 32'(sda_oe), 32'd0);

    // R4 wrap 0x7F -> 0x00
    i2c_start(); send_byte(ADR_W, a); send_byte(8'hFF, a);
    send_byte(8'h9A, a); send_byte(8'h41, a); i2c_stop();
    chk("R4 wrap to reg0", 32'(regs[0 +: 8]), 32'h41);
    chk("R8 discarded byte", 32'(regs[8 +: 8]), 32'hA5);

    // R5 fixed pointer
    i2c_start(); send_byte(ADR_W, a); send_byte(8'h02, a);
    send_byte(8'h5A, a); send_byte(8'h6B, a); i2c_stop();
    chk("R5 fixed write reg2", 32'({regs[24 +: 8], regs[16 +: 8]}), 32'h116B);
    set_map(8'h02, a2);
    i2c_start(); send_byte(ADR_R, a);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b0); i2c_stop();
    chk("R5 fixed read", 32'({d0, d1}), 32'h6B6B);

    // R1 mismatch
    i2c_start(); send_byte(ADR_BAD, a3[2]); send_byte(8'h02, a3[1]); send_byte(8'hEE, a3[0]); i2c_stop();
    chk("R1 mismatch no ack", 32'(a3), 32'h0);
    chk("R1 mismatch no write", 32'(regs[16 +: 8]), 32'h6B);

    // R11 repeated START after mismatch
    i2c_start(); send_byte(ADR_BAD, a3[2]);
    i2c_start(); send_byte(ADR_W, a3[1]); send_byte(8'h04, a); send_byte(8'hC8, a3[0]); i2c_stop();
    chk("R11 restart acks", 32'(a3), 32'h3);
    chk("R11 restart write", 32'(regs[32 +: 8]), 32'hC8);

    // R10 bus traffic during reset
    rst_n = 1'b0;
    wt(2);
    i2c_start(); send_byte(ADR_W, a3[2]); send_byte(8'h01, a3[1]); send_byte(8'h99, a3[0]); i2c_stop();
    chk("R10 no ack in reset", 32'(a3), 32'h0);
    chk("R10 regs cleared", 32'(regs[0 +: 48]), 32'h0);
    chk("R10 reg1 cleared", 32'(regs[8 +: 8]), 32'h0);
    rst_n = 1'b1;
    wt(4);
    chk("R9 core_rst_o after reset", 32'(core_rst), 32'd1);

    chk("R11 sda_oe stable while SCL high", 32'(edge_viol), 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule